// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is a chain of eight storage stages that either captures a whole byte at once or moves a bit stream through one place per clock. Only the final stage reaches the outside, so a captured byte leaves the block most significant bit first over the next clock cycles. A select input chooses between capture and shift. While it selects capture, the serial input is ignored.

The block runs from one free-running clock. An inhibit input stalls the chain while that clock keeps toggling. The inhibit acts as a clock enable on the stage flops, and the clock itself is never gated. The inhibit input may only be raised while the clock is high, so that a gated-clock build of the same logic would never see a false edge. An active-low clear is asynchronous. It empties every stage at once and overrides every other input. After the clear is released, the first enabled clock edge acts normally.

Top module: `piso_shift8`

## Requirements
- R1: The register holds STAGES (default 8) stages, numbered 0 (the input end) to STAGES-1 (the output end). `q_last` always shows stage STAGES-1. Bit i of `par_in` belongs to stage i, so the bit captured by a load that appears at once on `q_last` is `par_in[STAGES-1]`.
- R2: With `shift_sel` = 1 and `clk_inhibit` = 0, each rising `clk` edge moves every stage one place toward the output end, and `ser_in` enters stage 0.
- R3: With `shift_sel` = 0 and `clk_inhibit` = 0, `par_in` is copied into all stages at the next rising `clk` edge. Before that edge, `q_last` does not change.
- R4: During a load, `ser_in` has no effect on any stage.
- R5: With `clk_inhibit` = 1, every stage keeps its value across a rising edge, whatever the mode and data inputs are.
- R6: While `clear_n` = 0, every stage is 0 at once and stays 0 across clock edges, whatever the other inputs are.
- R7: `clk_inhibit` rises only while `clk` is high.
- R8: After `clear_n` returns to 1, the first rising edge with `clk_inhibit` = 0 performs the selected load or shift, with no removal delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; the stages act on its rising edge |
| clk_inhibit | input | 1 | 1 holds every stage; 0 lets the clock act |
| clear_n | input | 1 | Asynchronous active-low clear of all stages |
| shift_sel | input | 1 | 1 = serial shift, 0 = parallel load |
| ser_in | input | 1 | Serial bit that enters stage 0 on a shift |
| par_in | input | STAGES | Parallel byte; bit i loads stage i |
| q_last | output | 1 | Contents of the last stage |

## Verification
The bench builds the block with the default STAGES = 8. At that depth a loaded byte can be pushed out completely in eight shifts, and serial bits shifted in after a clear come into view on the output exactly eight edges later. With eight stages, a clear placed in the middle of a drain, and a load that arrives while bits are still in flight, each leave a distinct output trace. Inhibited edges are mixed into both fixed and pseudo-random runs. Every inhibit rise falls in the high clock phase.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int STAGES_DEFAULT = 8;

    // Select encoding on the shift_sel pin
    typedef enum logic {
        SEL_LOAD  = 1'b0,
        SEL_SHIFT = 1'b1
    } sel_e;

    // Action taken by every stage at a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } act_e;

    function automatic act_e decode_act(input logic inhibit, input sel_e sel);
        act_e a;
        if (inhibit)
            a = ACT_HOLD;
        else if (sel == SEL_SHIFT)
            a = ACT_SHIFT;
        else
            a = ACT_LOAD;
        return a;
    endfunction

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic clk_inhibit,
    input  logic shift_sel,
    output act_e act
);

    sel_e sel;

    always_comb begin
        sel = sel_e'(shift_sel);
        act = decode_act(clk_inhibit, sel);
    end

endmodule

// File: rtl/piso_stage.sv
module piso_stage
    import piso_pkg::*;
(
    input  logic clk,
    input  logic clear_n,
    input  act_e act,
    input  logic load_bit,
    input  logic prev_bit,
    output logic q
);

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            q <= 1'b0;
        end else begin
            case (act)
                ACT_LOAD:  q <= load_bit;
                ACT_SHIFT: q <= prev_bit;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/piso_shift8.sv
module piso_shift8
    import piso_pkg::*;
#(
    parameter int STAGES = STAGES_DEFAULT
) (
    input  logic              clk,
    input  logic              clk_inhibit,
    input  logic              clear_n,
    input  logic              shift_sel,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              q_last
);

    localparam int LAST = STAGES - 1;

    act_e              act;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] feed;

    piso_ctrl i_ctrl (
        .clk_inhibit (clk_inhibit),
        .shift_sel   (shift_sel),
        .act         (act)
    );

    assign feed = {stage_q[LAST-1:0], ser_in};

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        piso_stage i_stage (
            .clk      (clk),
            .clear_n  (clear_n),
            .act      (act),
            .load_bit (par_in[i]),
            .prev_bit (feed[i]),
            .q        (stage_q[i])
        );
    end

    assign q_last = stage_q[LAST];

endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              clk_inhibit,
    input logic              clear_n,
    input logic              shift_sel,
    input logic              ser_in,
    input logic [STAGES-1:0] par_in,
    input logic [STAGES-1:0] stage_q,
    input logic              q_last
);

    a_r3_load_copies: assert property (@(posedge clk) disable iff (!clear_n)
        (!clk_inhibit && !shift_sel) |=> (stage_q == $past(par_in)));

    a_r1_out_after_load: assert property (@(posedge clk) disable iff (!clear_n)
        (!clk_inhibit && !shift_sel) |=> (q_last == $past(par_in[STAGES-1])));

    a_r2_shift_moves: assert property (@(posedge clk) disable iff (!clear_n)
        (!clk_inhibit && shift_sel) |=>
            (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_in)}));

    a_r5_inhibit_holds: assert property (@(posedge clk) disable iff (!clear_n)
        clk_inhibit |=> $stable(stage_q));

    // R6: cleared contents sampled in the low clock phase
    always @(negedge clk) begin
        if (clear_n === 1'b0) begin
            a_r6_clear_zero: assert (stage_q == '0);
        end
    end

    // R7: an inhibit rise in the low phase would form a false edge
    always @(posedge clk_inhibit) begin
        if (clear_n === 1'b1) begin
            a_r7_inhibit_rise_phase: assert (clk === 1'b1);
        end
    end

endmodule

bind piso_shift8 piso_checker #(.STAGES(STAGES)) i_checker (
    .clk         (clk),
    .clk_inhibit (clk_inhibit),
    .clear_n     (clear_n),
    .shift_sel   (shift_sel),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .stage_q     (stage_q),
    .q_last      (q_last)
);

// File: tb/test_piso_shift8.sv
`timescale 1ns/1ps
module test_piso_shift8;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         clk_inhibit;
    logic         clear_n;
    logic         shift_sel;
    logic         ser_in;
    logic [N-1:0] par_in;
    logic         q_last;

    int checks = 0;
    int errors = 0;
    bit model [$];   // index 0 = input end, N-1 = output end

    piso_shift8 #(.STAGES(N)) i_piso_shift8 (
        .clk         (clk),
        .clk_inhibit (clk_inhibit),
        .clear_n     (clear_n),
        .shift_sel   (shift_sel),
        .ser_in      (ser_in),
        .par_in      (par_in),
        .q_last      (q_last)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running, expected finished");
        summary();
    end

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        model.delete();
        for (int i = 0; i < N; i++) model.push_back(1'b0);
    endtask

    // Called in the high clock phase; returns in the high phase after the next edge.
    task automatic step(input logic m, input logic inh, input logic s,
                        input logic [N-1:0] p, input string req);
        shift_sel   = m;
        clk_inhibit = inh;
        ser_in      = s;
        par_in      = p;
        #0.5;
        chk("R3 pre-edge output unchanged", q_last, model[N-1]);
        @(posedge clk);
        if (!inh) begin
            if (m) begin
                model.push_front(s);
                void'(model.pop_back());
            end else begin
                model.delete();
                for (int i = 0; i < N; i++) model.push_back(p[i]);
            end
        end
        #1;
        chk(req, q_last, model[N-1]);
    endtask

    task automatic clear_pulse();
        clear_n     = 1'b0;
        shift_sel   = 1'b1;
        ser_in      = 1'b1;
        clk_inhibit = 1'b0;
        par_in      = '1;
        model_clear();
        #0.5;
        chk("R6 clear immediate", q_last, 1'b0);
        @(posedge clk);
        #1;
        chk("R6 clear overrides shift", q_last, 1'b0);
        shift_sel = 1'b0;
        @(posedge clk);
        #1;
        chk("R6 clear overrides load", q_last, 1'b0);
        clear_n = 1'b1;
    endtask

    initial begin
        logic [15:0] lfsr;
        clear_n     = 1'b0;
        clk_inhibit = 1'b0;
        shift_sel   = 1'b0;
        ser_in      = 1'b0;
        par_in      = '0;
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        chk("R6 reset state", q_last, 1'b0);
        clear_n = 1'b1;

        // R8 first edge after release loads; R1 MSB appears
        step(1'b0, 1'b0, 1'b0, 8'hA5, "R8 first edge after release");
        chk("R1 load shows par_in[7]", q_last, 1'b1);

        // R2 drain the byte and feed a serial pattern
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, i[0], 8'h00, "R2 shift drain");

        // R4 loads with serial input at both levels
        step(1'b0, 1'b0, 1'b1, 8'h3C, "R4 load ignores ser_in=1");
        step(1'b0, 1'b0, 1'b0, 8'hC3, "R4 load ignores ser_in=0");
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, 1'b1, 8'h00, "R4 drain after load");

        // R5 and R7: inhibit raised in the high phase, mode and data toggled
        step(1'b0, 1'b0, 1'b0, 8'h7F, "R5 setup load");
        step(1'b1, 1'b1, 1'b1, 8'hFF, "R5 R7 inhibit holds on shift");
        step(1'b0, 1'b1, 1'b1, 8'hFF, "R5 R7 inhibit holds on load");
        step(1'b1, 1'b1, 1'b0, 8'h00, "R5 R7 inhibit holds again");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R5 resume after inhibit");

        // R6 clear in the middle of a shift sequence, then R8 resume
        step(1'b0, 1'b0, 1'b0, 8'hFF, "R6 setup load");
        step(1'b1, 1'b0, 1'b1, 8'h00, "R6 shift before clear");
        step(1'b1, 1'b0, 1'b1, 8'h00, "R6 shift before clear");
        clear_pulse();
        for (int i = 0; i < 9; i++)
            step(1'b1, 1'b0, 1'b1, 8'h00, "R8 shift ones after clear");

        // Mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], (lfsr[2] & lfsr[3]), lfsr[4], lfsr[12:5],
                 "R2 R3 R5 mixed traffic");
        end

        summary();
    end

endmodule